// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a shared word store reached through two independent access ports, A and B, so that two processors can pass data to each other. Each port carries its own word address, active-low select, write strobe and output gate, a data-in bus, and a registered data-out bus with a drive flag. The drive flag takes the place of a tri-state pin: when it is low, the port's data output is treated as high impedance and is held at zero.

An external contention arbiter supplies one active-low not-ready input per port. A port whose not-ready is low loses its write for that cycle without any notice, but it can still read. Both ports can read or write in the same clock. Writes land on the rising clock edge. A read samples the word as it stood before that edge and presents it one cycle later. The whole model runs on one clock. It takes an asynchronous active-low reset that is released through a two-stage synchronizer.

Top module: `mbox_dpram`

## Requirements
- R1: A port with select low, write strobe low and not-ready high stores its data-in at its address on the clock edge, and a later read of that address returns the value.
- R2: A port with select low, write strobe high and output gate low raises its drive flag one cycle later and presents the addressed word on its data output.
- R3: A port with select high does not read or write. One cycle later its drive flag is low and its data output is zero.
- R4: A port with its output gate high has its drive flag low and its data output zero one cycle later. This also holds while that port is writing.
- R5: A write attempted while the port's not-ready input is low leaves the storage unchanged. A read on that port still works.
- R6: A read on one port in the same cycle as a write on the other port to the same address returns the word as it stood before the write.
- R7: Writes from both ports to different addresses in the same cycle both complete.
- R8: When both ports write the same address in the same cycle, port A's data is the value stored.
- R9: Two reads of the same address in the same cycle return identical data on both ports.
- R10: While reset is active, both drive flags are low and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output gate, active low |
| a_nrdy_n | input | 1 | Port A not-ready from the arbiter, active low |
| a_addr | input | 8 | Port A word address |
| a_din | input | 8 | Port A write data |
| a_dout | output | 8 | Port A read data, zero when not driven |
| a_dout_en | output | 1 | Port A drive flag |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output gate, active low |
| b_nrdy_n | input | 1 | Port B not-ready from the arbiter, active low |
| b_addr | input | 8 | Port B word address |
| b_din | input | 8 | Port B write data |
| b_dout | output | 8 | Port B read data, zero when not driven |
| b_dout_en | output | 1 | Port B drive flag |

## Verification
The drive flag and data output of each port are due exactly one rising edge after the controls that request them. A stored word becomes visible to a read issued in the cycle after the write, and a read in the write's own cycle still sees the old contents. The bench changes inputs one time unit after an edge. It predicts each port's outputs from the controls and from a reference copy of the storage as it stood before that edge, then samples one time unit after the next edge. Only after that check does it apply the cycle's writes to the reference, with port B first and port A last.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int NPORT  = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  // Decoded per-port operation for one cycle
  typedef struct packed {
    logic wr;   // store data-in this edge
    logic rd;   // capture addressed word this edge
  } port_op_t;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
(
  input  logic     cs_n,
  input  logic     we_n,
  input  logic     oe_n,
  input  logic     nrdy_n,
  output port_op_t op
);

  // A not-ready port keeps its read path but loses its write.
  always_comb begin
    op.wr = ~cs_n & ~we_n & nrdy_n;
    op.rd = ~cs_n &  we_n & ~oe_n;
  end

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage carries no reset. Port B is applied first so that port A
  // overrides it when both target the same word.
  always_ff @(posedge clk) begin
    if (wr_b) begin
      mem[addr_b] <= din_b;
    end
    if (wr_a) begin
      mem[addr_a] <= din_a;
    end
  end

  // Reads see the contents before this edge's writes.
  always_comb begin
    rdata_a = mem[addr_a];
    rdata_b = mem[addr_b];
  end

endmodule

// File: rtl/mbox_rd_stage.sv
module mbox_rd_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              en_q, en_d;

  // Next state: data register loads only on a read.
  always_comb begin
    en_d   = rd;
    data_d = rd ? rdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      data_q <= data_d;
    end
  end

  // An undriven output reads as zero.
  assign dout_en = en_q;
  assign dout    = en_q ? data_q : '0;

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic              a_nrdy_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_dout_en,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic              b_nrdy_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_dout_en
);

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  // Per-port bundling
  logic [NPORT-1:0]  cs_n, we_n, oe_n, nrdy_n, dout_en;
  logic [ADDR_W-1:0] addr  [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];
  logic [DATA_W-1:0] dout  [NPORT];
  port_op_t          op    [NPORT];

  assign cs_n   = {b_cs_n,   a_cs_n};
  assign we_n   = {b_we_n,   a_we_n};
  assign oe_n   = {b_oe_n,   a_oe_n};
  assign nrdy_n = {b_nrdy_n, a_nrdy_n};
  assign addr[PORT_A] = a_addr;
  assign addr[PORT_B] = b_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    mbox_port_dec u_dec (
      .cs_n   (cs_n[g]),
      .we_n   (we_n[g]),
      .oe_n   (oe_n[g]),
      .nrdy_n (nrdy_n[g]),
      .op     (op[g])
    );

    mbox_rd_stage #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rd      (op[g].rd),
      .rdata   (rdata[g]),
      .dout    (dout[g]),
      .dout_en (dout_en[g])
    );
  end

  mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_a    (op[PORT_A].wr),
    .addr_a  (addr[PORT_A]),
    .din_a   (a_din),
    .wr_b    (op[PORT_B].wr),
    .addr_b  (addr[PORT_B]),
    .din_b   (b_din),
    .rdata_a (rdata[PORT_A]),
    .rdata_b (rdata[PORT_B])
  );

  assign a_dout    = dout[PORT_A];
  assign a_dout_en = dout_en[PORT_A];
  assign b_dout    = dout[PORT_B];
  assign b_dout_en = dout_en[PORT_B];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_cs_n,
  input logic              a_we_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_dout,
  input logic              a_dout_en,
  input logic              b_cs_n,
  input logic              b_we_n,
  input logic              b_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_dout,
  input logic              b_dout_en
);

  // R2
  a_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && a_we_n && !a_oe_n) |=> a_dout_en);

  // R2
  b_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && b_we_n && !b_oe_n) |=> b_dout_en);

  // R3
  a_deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_cs_n |=> (!a_dout_en && a_dout == '0));

  // R3
  b_deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_cs_n |=> (!b_dout_en && b_dout == '0));

  // R4
  a_gate_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |=> !a_dout_en);

  // R4
  b_gate_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe_n |=> !b_dout_en);

  // R9
  same_addr_reads_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && a_we_n && !a_oe_n && !b_cs_n && b_we_n && !b_oe_n &&
     a_addr == b_addr) |=> (a_dout == b_dout));

endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .a_cs_n    (a_cs_n),
  .a_we_n    (a_we_n),
  .a_oe_n    (a_oe_n),
  .a_addr    (a_addr),
  .a_dout    (a_dout),
  .a_dout_en (a_dout_en),
  .b_cs_n    (b_cs_n),
  .b_we_n    (b_we_n),
  .b_oe_n    (b_oe_n),
  .b_addr    (b_addr),
  .b_dout    (b_dout),
  .b_dout_en (b_dout_en)
);

// File: tb/mbox_dpram_bench.sv
module mbox_dpram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_cs_n, a_we_n, a_oe_n, a_nrdy_n;
  logic          b_cs_n, b_we_n, b_oe_n, b_nrdy_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_din, b_din, a_dout, b_dout;
  logic          a_dout_en, b_dout_en;

  int compared = 0;
  int mismatched = 0;
  logic [DW-1:0] ref_mem [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_dpram u_mbox_dpram (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_nrdy_n(a_nrdy_n),
    .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout), .a_dout_en(a_dout_en),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_nrdy_n(b_nrdy_n),
    .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout), .b_dout_en(b_dout_en)
  );

  function automatic logic is_rd(logic cs, logic we, logic oe);
    return !cs && we && !oe;
  endfunction

  function automatic logic is_wr(logic cs, logic we, logic nr);
    return !cs && !we && nr;
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_a(logic cs, logic we, logic oe, logic nr, logic [AW-1:0] ad, logic [DW-1:0] d);
    a_cs_n = cs; a_we_n = we; a_oe_n = oe; a_nrdy_n = nr; a_addr = ad; a_din = d;
  endtask

  task automatic set_b(logic cs, logic we, logic oe, logic nr, logic [AW-1:0] ad, logic [DW-1:0] d);
    b_cs_n = cs; b_we_n = we; b_oe_n = oe; b_nrdy_n = nr; b_addr = ad; b_din = d;
  endtask

  function automatic string auto_tag(logic cs, logic we, logic oe, logic [AW-1:0] ad,
                                     logic ow, logic [AW-1:0] oad);
    if (cs) return "R3";
    if (oe) return "R4";
    if (we && ow && ad == oad) return "R6";
    return "R2";
  endfunction

  // One clock: predict, advance, compare, then apply writes to the reference.
  task automatic cyc(string tag_a, string tag_b);
    logic          ea, eb, wa, wb;
    logic [DW-1:0] xa, xb;
    string         ta, tb;
    ea = is_rd(a_cs_n, a_we_n, a_oe_n);
    eb = is_rd(b_cs_n, b_we_n, b_oe_n);
    wa = is_wr(a_cs_n, a_we_n, a_nrdy_n);
    wb = is_wr(b_cs_n, b_we_n, b_nrdy_n);
    xa = ea ? ref_mem[a_addr] : '0;
    xb = eb ? ref_mem[b_addr] : '0;
    ta = (tag_a != "") ? tag_a : auto_tag(a_cs_n, a_we_n, a_oe_n, a_addr, wb, b_addr);
    tb = (tag_b != "") ? tag_b : auto_tag(b_cs_n, b_we_n, b_oe_n, b_addr, wa, a_addr);
    @(posedge clk); #1;
    check(ta, "a_dout_en", {7'd0, a_dout_en}, {7'd0, ea});
    check(ta, "a_dout", a_dout, xa);
    check(tb, "b_dout_en", {7'd0, b_dout_en}, {7'd0, eb});
    check(tb, "b_dout", b_dout, xb);
    if (wb) ref_mem[b_addr] = b_din;
    if (wa) ref_mem[a_addr] = a_din;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    set_a(1'b0, 1'b1, 1'b0, 1'b1, '0, '0);   // read requested during reset
    set_b(1'b0, 1'b1, 1'b0, 1'b1, '0, '0);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs quiet while in reset despite read requests
    check("R10", "a_dout_en", {7'd0, a_dout_en}, 8'd0);
    check("R10", "a_dout", a_dout, 8'd0);
    check("R10", "b_dout_en", {7'd0, b_dout_en}, 8'd0);
    check("R10", "b_dout", b_dout, 8'd0);
    set_a(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    set_b(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // Fill: both ports write disjoint halves each cycle (R7)
    for (int i = 0; i < NW/2; i++) begin
      set_a(1'b0, 1'b0, 1'b1, 1'b1, AW'(i), DW'($urandom));
      set_b(1'b0, 1'b0, 1'b1, 1'b1, AW'(i + NW/2), DW'($urandom));
      cyc("", "");
    end
    // R7: read back two words of the fill
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 8'd10, '0);
    set_b(1'b0, 1'b1, 1'b0, 1'b1, 8'd138, '0);
    cyc("R7", "R7");

    // R1: write then read on A
    set_a(1'b0, 1'b0, 1'b1, 1'b1, 8'd5, 8'h3C);
    set_b(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    cyc("", "");
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 8'd5, '0);
    cyc("R1", "");

    // R5: blocked write on B, then read it back on B
    set_a(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    set_b(1'b0, 1'b0, 1'b1, 1'b0, 8'd9, ~ref_mem[9]);
    cyc("", "");
    set_b(1'b0, 1'b1, 1'b0, 1'b0, 8'd9, '0);
    cyc("", "R5");

    // R8: both write the same word, A wins
    set_a(1'b0, 1'b0, 1'b1, 1'b1, 8'd77, 8'hA5);
    set_b(1'b0, 1'b0, 1'b1, 1'b1, 8'd77, 8'h5A);
    cyc("", "");
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 8'd77, '0);
    set_b(1'b0, 1'b1, 1'b0, 1'b1, 8'd77, '0);
    cyc("R8", "R9");

    // R6: B reads while A overwrites the same word
    set_a(1'b0, 1'b0, 1'b1, 1'b1, 8'd77, 8'hC3);
    set_b(1'b0, 1'b1, 1'b0, 1'b1, 8'd77, '0);
    cyc("R4", "R6");
    set_a(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    cyc("R3", "R1");

    // Random traffic with dense address collisions
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        logic [AW-1:0] ad;
        logic cs, we, oe, nr;
        ad = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 8);
        cs = (($urandom % 5) == 0);
        we = $urandom % 2;
        oe = (($urandom % 4) == 0);
        nr = (($urandom % 5) != 0);
        if (p == 0) set_a(cs, we, oe, nr, ad, DW'($urandom));
        else        set_b(cs, we, oe, nr, ad, DW'($urandom));
      end
      cyc("", "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule